// File: doc/BRIEF.md
# Sweeping-Period Square-Wave Generator

This block drives a single square-wave output whose period walks from a starting value toward a target value. The period comes from a 16-bit unsigned fixed-point accumulator: its upper byte is the integer count `n` of timer ticks per period, and its lower byte holds the fractional part. Ticks come from the clock divided by four and then by a selectable prescaler of 1, 4 or 16. One output period therefore lasts (n + 1) × 4 × prescale clock cycles. At the end of every output period, a signed step is added to the accumulator. The high time is set to half of `n` and is recomputed together with `n`, so the duty cycle stays close to 50% throughout the sweep.

All period changes take effect only when the period counter wraps. A shrinking period can therefore never leave the counter above its new terminal value. Because there is one step per output period, short periods step more often than long ones, and the sweep is not linear in time.

A one-cycle `start_i` pulse does the following: it captures the start period, end period, step and prescaler select; it zeroes the counters; it clears the done flag; and it starts the output. The sweep stops when the integer period reaches or passes the end period in the direction of the step. The done flag is raised at that point, and the output keeps toggling at the final period. A step of zero gives a steady tone.

Top module: `sweep_pwm`

## Requirements
- R1: While reset is low and after its release until the first start, `pwm_o` and `done_o` are both 0.
- R2: In the clock cycle after `start_i` is sampled high, `pwm_o` is 1. This holds even if a sweep was already running, and the first period then begins in that cycle with `n` equal to the captured start period.
- R3: The prescaler select picks the divisor: 0 gives 1, 1 gives 4, and 2 or 3 give 16. Each output period lasts (n + 1) × 4 × divisor clock cycles, measured between rising edges of `pwm_o`.
- R4: In each period, `pwm_o` is high for (n >> 1) × 4 × divisor cycles. It goes high at the start of the period and low for the rest of it.
- R5: The start loads the accumulator with the start period in bits [15:8] and zeros in bits [7:0]. At each period wrap, while not done, the accumulator gains the signed 16-bit step. The new `n` is the accumulator shifted right by 8 with zero fill, and it governs the period that begins at that wrap.
- R6: A decreasing sweep produces only complete periods of the expected lengths. The period counter never exceeds the current `n`.
- R7: `done_o` rises at the wrap whose update gives n ≥ end (positive step) or n ≤ end (negative step). After that the accumulator is frozen and the output keeps the last period. `done_o` stays high until the next start.
- R8: With a step of zero, every period equals the start period and `done_o` stays 0.
- R9: An update that would exceed 0xFFFF saturates to 0xFFFF, and one that would go below 0 saturates to 0.
- R10: A start during a sweep that is running or finished clears `done_o` and restarts the counters mid-period.
- R11: Changes to the period, step and prescaler inputs while a sweep runs have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that captures settings and starts a sweep |
| start_per_i | input | 8 | Integer period count at the start of the sweep |
| end_per_i | input | 8 | Integer period count that ends the sweep |
| rate_i | input | 16 | Signed fixed-point step added once per output period (8 fraction bits) |
| pre_sel_i | input | 2 | Prescaler select: 0 gives /1, 1 gives /4, 2 and 3 give /16 |
| pwm_o | output | 1 | Square-wave output |
| done_o | output | 1 | High once the sweep has reached its end period |

## Verification
A wrong accumulator or step value shows up at the ports within one output period. The next measured period length departs from the reference sequence, and the error grows as the sweep continues. A counter that slips past its terminal value on a shrinking period appears as a single period that lasts about 256 ticks too long. A missed or early done decision changes whether the period keeps stepping after the end value, which is visible in the first period after the crossing. A wrong duty computation changes the measured high time in the same period in which `n` changes.

// File: rtl/sweep_pwm_pkg.sv
// Shared constants and helpers for the sweeping-period square-wave generator.
// Assumes the fixed divide-by-four stage ahead of the prescaler.
package sweep_pwm_pkg;

    // Fixed divide applied ahead of the selectable prescaler.
    localparam int unsigned BASE_DIV = 4;
    // Largest prescaler value; used to size the tick divider.
    localparam int unsigned PRE_MAX  = 16;

    typedef enum logic [1:0] {
        PRE_BY1   = 2'd0,
        PRE_BY4   = 2'd1,
        PRE_BY16  = 2'd2,
        PRE_BY16B = 2'd3
    } pre_sel_e;

    // Maps a prescaler select code to its divisor.
    function automatic int unsigned pre_factor(input logic [1:0] sel);
        case (pre_sel_e'(sel))
            PRE_BY1: pre_factor = 1;
            PRE_BY4: pre_factor = 4;
            default: pre_factor = 16;
        endcase
    endfunction

endpackage

// File: rtl/sweep_tick_gen.sv
// Tick generator: emits a one-cycle tick every BASE_DIV * prescale clocks
// while the sweep runs. The divider is cleared by restart so that the
// first tick of a sweep arrives a full tick interval after start.
module sweep_tick_gen
    import sweep_pwm_pkg::*;
#(
    parameter int unsigned DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       run_i,
    input  logic [1:0] pre_sel_i,
    output logic       tick_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] term;

    // Last divider value of one tick interval.
    always_comb begin
        term = DIV_W'(BASE_DIV * pre_factor(pre_sel_i) - 1);
    end

    // Divider count, cleared on restart and wrapped at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart_i) begin
            div_q <= '0;
        end else if (run_i) begin
            if (div_q == term) div_q <= '0;
            else               div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run_i && (div_q == term);

    // R3: ticks are never adjacent, since the smallest interval is four clocks.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart_i) |=> !tick_o);

endmodule

// File: rtl/sweep_period_timer.sv
// Period timer: counts ticks from 0 to the current period count and wraps.
// The output level is high while the count is below the compare value.
// Assumes the period and compare inputs change only at a wrap or a restart.
module sweep_period_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_n_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             wrap_o,
    output logic             level_o
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap_o  = tick_i && (cnt_q == period_n_i);
    assign level_o = (cnt_q < cmp_i);

    // Tick counter over one output period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the count never lies above the period it is timing.
    assert_cnt_within_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= period_n_i);

endmodule

// File: rtl/sweep_ramp_ctrl.sv
// Ramp controller: holds the fixed-point period accumulator, captures the
// sweep settings on start, applies the signed step at each period wrap with
// saturation, derives the compare value, and decides when the sweep is done.
// Assumes wrap_i pulses exactly once per output period.
module sweep_ramp_ctrl #(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned INT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [INT_W-1:0]        start_per_i,
    input  logic [INT_W-1:0]        end_per_i,
    input  logic signed [ACC_W-1:0] rate_i,
    input  logic [1:0]              pre_sel_i,
    input  logic                    wrap_i,
    output logic [INT_W-1:0]        period_n_o,
    output logic [INT_W-1:0]        cmp_o,
    output logic [1:0]              pre_sel_o,
    output logic                    running_o,
    output logic                    done_o
);

    localparam int unsigned FRAC_W = ACC_W - INT_W;
    localparam int unsigned SUM_W  = ACC_W + 2;

    logic [ACC_W-1:0]        acc_q;
    logic signed [ACC_W-1:0] rate_q;
    logic [INT_W-1:0]        end_q;
    logic [INT_W-1:0]        cmp_q;
    logic [1:0]              pre_q;
    logic                    running_q;
    logic                    done_q;

    logic signed [SUM_W-1:0] sum;
    logic [ACC_W-1:0]        acc_next;
    logic [INT_W-1:0]        n_next;
    logic                    rate_pos;
    logic                    rate_neg;
    logic                    reached;

    // Stepped accumulator, saturated to the unsigned range.
    always_comb begin
        sum = $signed({2'b00, acc_q}) + $signed({{2{rate_q[ACC_W-1]}}, rate_q});
        if (sum[SUM_W-1])      acc_next = '0;
        else if (sum[SUM_W-2]) acc_next = '1;
        else                   acc_next = sum[ACC_W-1:0];
    end

    // Integer part of the stepped value and the end-of-sweep decision.
    always_comb begin
        n_next   = INT_W'(acc_next >> FRAC_W);
        rate_neg = rate_q[ACC_W-1];
        rate_pos = !rate_neg && (rate_q != '0);
        reached  = (rate_pos && (n_next >= end_q)) ||
                   (rate_neg && (n_next <= end_q));
    end

    // Settings capture on start, then one step per wrap until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            rate_q    <= '0;
            end_q     <= '0;
            cmp_q     <= '0;
            pre_q     <= '0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (start_i) begin
            acc_q     <= {start_per_i, {FRAC_W{1'b0}}};
            rate_q    <= rate_i;
            end_q     <= end_per_i;
            cmp_q     <= start_per_i >> 1;
            pre_q     <= pre_sel_i;
            running_q <= 1'b1;
            done_q    <= 1'b0;
        end else if (wrap_i && !done_q) begin
            acc_q     <= acc_next;
            cmp_q     <= n_next >> 1;
            done_q    <= reached;
        end
    end

    assign period_n_o = INT_W'(acc_q >> FRAC_W);
    assign cmp_o      = cmp_q;
    assign pre_sel_o  = pre_q;
    assign running_o  = running_q;
    assign done_o     = done_q;

    // R5: the accumulator moves only at a start or at a period wrap.
    assert_acc_hold_between_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !wrap_i) |=> $stable(acc_q));

    // R7: once done, the flag stays high until a new start.
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> done_q);

    // R7: a finished sweep keeps its period.
    assert_frozen_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_i) |=> $stable(acc_q));

    // R8: a zero step never moves the period or raises done.
    assert_zero_rate_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && rate_q == '0 && !start_i) |=> ($stable(acc_q) && !$rose(done_q)));

    // R4: the registered compare value always tracks half of the live period.
    assert_cmp_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cmp_q == (period_n_o >> 1)));

endmodule

// File: rtl/sweep_pwm.sv
// Top of the sweeping-period square-wave generator. It ties the ramp
// controller, the tick generator and the period timer together. The output
// is gated low until the first start.
module sweep_pwm
    import sweep_pwm_pkg::*;
#(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned INT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [INT_W-1:0]        start_per_i,
    input  logic [INT_W-1:0]        end_per_i,
    input  logic signed [ACC_W-1:0] rate_i,
    input  logic [1:0]              pre_sel_i,
    output logic                    pwm_o,
    output logic                    done_o
);

    localparam int unsigned DIV_W = $clog2(BASE_DIV * PRE_MAX);

    logic [INT_W-1:0] period_n;
    logic [INT_W-1:0] cmp;
    logic [1:0]       pre_q;
    logic             running;
    logic             tick;
    logic             wrap;
    logic             level;

    sweep_ramp_ctrl #(.ACC_W(ACC_W), .INT_W(INT_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_per_i(start_per_i),
        .end_per_i  (end_per_i),
        .rate_i     (rate_i),
        .pre_sel_i  (pre_sel_i),
        .wrap_i     (wrap),
        .period_n_o (period_n),
        .cmp_o      (cmp),
        .pre_sel_o  (pre_q),
        .running_o  (running),
        .done_o     (done_o)
    );

    sweep_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .run_i     (running),
        .pre_sel_i (pre_q),
        .tick_o    (tick)
    );

    sweep_period_timer #(.CNT_W(INT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (start_i),
        .tick_i     (tick),
        .period_n_i (period_n),
        .cmp_i      (cmp),
        .wrap_o     (wrap),
        .level_o    (level)
    );

    assign pwm_o = running && level;

    // R1: nothing is driven before the first start.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pwm_o && !done_o));

endmodule

// File: tb/sweep_pwm_tb.sv
// Directed bench: each scenario task starts a sweep, measures every output
// period between rising edges, and compares it with a model of the sweep.
module sweep_pwm_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [7:0]         start_per_i = '0;
    logic [7:0]         end_per_i = '0;
    logic signed [15:0] rate_i = '0;
    logic [1:0]         pre_sel_i = '0;
    logic               pwm_o;
    logic               done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sweep_pwm dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_per_i(start_per_i),
        .end_per_i  (end_per_i),
        .rate_i     (rate_i),
        .pre_sel_i  (pre_sel_i),
        .pwm_o      (pwm_o),
        .done_o     (done_o)
    );

    // Counts one check and reports it on mismatch.
    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Starts a sweep, scrambles the inputs (R11), then measures nper periods.
    task automatic run_sweep(input string tag, input int sp, input int ep,
                             input int rt, input int ps, input int nper);
        int dv;
        int acc;
        int n;
        int sum;
        bit dn;
        int len;
        int hi;
        bit prev;
        bit rose;
        int guard;
        dv  = 4 * ((ps == 0) ? 1 : (ps == 1) ? 4 : 16);
        acc = sp * 256;
        dn  = 1'b0;
        @(negedge clk);
        start_per_i = sp[7:0];
        end_per_i   = ep[7:0];
        rate_i      = rt[15:0];
        pre_sel_i   = ps[1:0];
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
        // R11: these values must be ignored for the rest of the sweep.
        start_per_i = 8'd3;
        end_per_i   = 8'd200;
        rate_i      = 16'sh7F00;
        pre_sel_i   = ~ps[1:0];
        // R2: output is high in the cycle after start.
        chk(pwm_o == 1'b1, {tag, " R2"}, "pwm after start", pwm_o, 1);
        for (int i = 0; i < nper; i++) begin
            if (i > 0 && !dn) begin
                sum = acc + rt;
                if (sum < 0) sum = 0;
                if (sum > 65535) sum = 65535;
                acc = sum;
                n   = acc / 256;
                if ((rt > 0 && n >= ep) || (rt < 0 && n <= ep)) dn = 1'b1;
            end
            n = acc / 256;
            chk(done_o == dn, {tag, " R7"}, $sformatf("done at period %0d", i), done_o, dn);
            len = 1; hi = 1; prev = 1'b1; rose = 1'b0; guard = 0;
            while (!rose && guard < 5000) begin
                @(negedge clk);
                guard++;
                if (pwm_o && !prev) rose = 1'b1;
                else begin
                    len++;
                    if (pwm_o) hi++;
                end
                prev = pwm_o;
            end
            chk(rose, {tag, " R6"}, $sformatf("period %0d ended", i), rose, 1);
            chk(len == (n + 1) * dv, {tag, " R3 R5"}, $sformatf("period %0d length", i),
                len, (n + 1) * dv);
            chk(hi == (n / 2) * dv, {tag, " R4"}, $sformatf("period %0d high time", i),
                hi, (n / 2) * dv);
        end
    endtask

    // R1: outputs quiet in and after reset.
    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(pwm_o == 1'b0, "R1", "pwm in reset", pwm_o, 0);
        chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(pwm_o == 1'b0, "R1", "pwm idle", pwm_o, 0);
        chk(done_o == 1'b0, "R1", "done idle", done_o, 0);
    endtask

    // R6 R5 R7: shrinking period with fractional step, /1.
    task automatic test_shrinking();
        run_sweep("R6 shrink", 40, 20, -640, 0, 11);
    endtask

    // R10 R3: growing period with /4, started over a finished sweep.
    task automatic test_growing_restart();
        run_sweep("R10 grow", 10, 14, 384, 1, 6);
    endtask

    // R8 R3: steady tone at /16, both select codes.
    task automatic test_steady_tone();
        run_sweep("R8 steady", 5, 9, 0, 2, 4);
        run_sweep("R8 steady sel3", 3, 9, 0, 3, 2);
    endtask

    // R9: upward saturation at the top of the accumulator.
    task automatic test_saturate();
        run_sweep("R9 saturate", 250, 255, 2048, 0, 3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_shrinking();
        test_growing_restart();
        test_steady_tone();
        test_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule